// File: doc/BRIEF.md
# Dual-Path Carry-Save Column Reducer

This block reduces one column of a multiply-accumulate array: it takes 64 three-bit partial products in a single cycle and returns their sum. A mode input selects between two's-complement products (signed mode) and unsigned two-bit magnitudes (unsigned mode). The block is meant to sit below a column of bit-serial multipliers. Accumulation across activation bits is left to the logic that follows it.

The block does not use a binary tree of carry-propagate adders. Each product is split into its top bit and its two low bits, and the two parts travel separate paths. The low bits pass through levels of 3:2 compressors, which produce a sum vector and a carry vector and propagate no carries. The top bits are counted; in signed mode each one carries a weight of minus four. A single final adder joins the carry-save vectors and the weighted count. A parameter adds one output register stage.

Top module: `csa_column_reducer`

## Requirements
- R1: `col_sum` equals the sum of all 64 products. Product i sits at bits [3i+2:3i] of `prod_bus`. In signed mode each product is read as a 3-bit two's-complement value (-4 to +3).
- R2: In signed mode the result spans -256 to +192: all products 3'b100 give -256, all products 3'b011 give +192, and all products 3'b111 give -64.
- R3: In unsigned mode the top bit of every product is ignored and each product counts as its two low bits (0 to 3), so the result lies in 0 to 192. All products 3'b111 give +192 and all products 3'b100 give 0.
- R4: With `REG_OUT`=1 the result appears on `col_sum` one clock edge after the inputs are applied, and it holds until that edge. With `REG_OUT`=0 the result follows the inputs with no clock edge.
- R5: While `rst_n` is low, the registered `col_sum` is 0, whatever the inputs are.
- R6: The block keeps no state between samples. When `signed_mode` changes while the products stay the same, the next result follows the new mode alone.
- R7: `col_sum` is a 9-bit two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| signed_mode | input | 1 | 1: products are two's complement; 0: unsigned two-bit magnitudes |
| prod_bus | input | 192 | 64 packed 3-bit partial products, product i at [3i+2:3i] |
| col_sum | output | 9 | Signed column sum |

## Verification
In the registered variant, a sum is due one rising edge after its products and mode are applied. The bench therefore drives inputs on a falling edge, confirms just before the next rising edge that the old value still holds, and reads the new sum on the falling edge after that. A combinational instance fed with the same stimulus is read a few nanoseconds after each drive, with no clock edge in between. The reset value is read while reset is still asserted and the products are non-zero.

// File: rtl/csa_colred_pkg.sv
package csa_colred_pkg;

  // Operand count after one level of 3:2 compression.
  function automatic int next_count(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Operand count after a given number of levels.
  function automatic int count_at(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = next_count(c);
    return c;
  endfunction

  // Levels needed to reach two operands.
  function automatic int levels_for(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = next_count(c);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/csa_compressor.sv
module csa_compressor #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] maj;

  always_comb begin
    sum_o   = in_a ^ in_b ^ in_c;
    maj     = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
    carry_o = {maj[W-2:0], 1'b0};
  end
endmodule

// File: rtl/csa_low_tree.sv
module csa_low_tree
  import csa_colred_pkg::*;
#(
  parameter int N     = 64,
  parameter int LOW_W = 2,
  parameter int ACC_W = 8
) (
  input  logic [LOW_W-1:0] low_ops [N],
  output logic [ACC_W-1:0] sum_vec,
  output logic [ACC_W-1:0] carry_vec
);
  localparam int LEVELS = levels_for(N);

  logic [ACC_W-1:0] ops [LEVELS+1][N];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign ops[0][i] = {{(ACC_W-LOW_W){1'b0}}, low_ops[i]};
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int PREV = count_at(N, l - 1);
    localparam int CUR  = count_at(N, l);
    localparam int GRP  = PREV / 3;
    localparam int REM  = PREV % 3;

    for (genvar g = 0; g < GRP; g++) begin : g_csa
      csa_compressor #(.W(ACC_W)) u_cmp (
        .in_a   (ops[l-1][3*g]),
        .in_b   (ops[l-1][3*g+1]),
        .in_c   (ops[l-1][3*g+2]),
        .sum_o  (ops[l][2*g]),
        .carry_o(ops[l][2*g+1])
      );
    end
    for (genvar r = 0; r < REM; r++) begin : g_pass
      assign ops[l][2*GRP+r] = ops[l-1][3*GRP+r];
    end
    for (genvar k = CUR; k < N; k++) begin : g_zero
      assign ops[l][k] = '0;
    end
  end

  assign sum_vec   = ops[LEVELS][0];
  assign carry_vec = ops[LEVELS][1];
endmodule

// File: rtl/csa_msb_counter.sv
module csa_msb_counter #(
  parameter int N     = 64,
  parameter int CNT_W = 7
) (
  input  logic [N-1:0]     msb_bits,
  output logic [CNT_W-1:0] msb_cnt
);
  always_comb begin
    msb_cnt = '0;
    for (int i = 0; i < N; i++) begin
      msb_cnt = msb_cnt + CNT_W'(msb_bits[i]);
    end
  end
endmodule

// File: rtl/csa_merge_adder.sv
module csa_merge_adder #(
  parameter int ACC_W  = 8,
  parameter int CNT_W  = 7,
  parameter int OUT_W  = 9,
  parameter int NEG_SH = 2
) (
  input  logic [ACC_W-1:0]        sum_vec,
  input  logic [ACC_W-1:0]        carry_vec,
  input  logic [CNT_W-1:0]        msb_cnt,
  output logic signed [OUT_W-1:0] total
);
  logic [OUT_W-1:0] pos_part;
  logic [OUT_W-1:0] neg_part;

  always_comb begin
    pos_part = OUT_W'(sum_vec) + OUT_W'(carry_vec);
    neg_part = OUT_W'(msb_cnt) << NEG_SH;
    total    = $signed(pos_part - neg_part);
  end
endmodule

// File: rtl/csa_column_reducer.sv
module csa_column_reducer #(
  parameter int N       = 64,
  parameter int PW      = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        signed_mode,
  input  logic [N*PW-1:0]                             prod_bus,
  output logic signed [$clog2(N*(2**(PW-1)))+1-1:0]   col_sum
);
  localparam int LOW_W   = PW - 1;
  localparam int LOW_MAX = (2**LOW_W) - 1;
  localparam int NEG_WT  = 2**LOW_W;
  localparam int ACC_W   = $clog2(N*LOW_MAX + 1);
  localparam int CNT_W   = $clog2(N + 1);
  localparam int OUT_W   = $clog2(N*NEG_WT) + 1;
  localparam logic signed [OUT_W-1:0] MAX_POS = OUT_W'(N*LOW_MAX);
  localparam logic signed [OUT_W-1:0] MIN_NEG = -OUT_W'(N*NEG_WT);

  logic [N-1:0]             msb_bits;
  logic [LOW_W-1:0]         low_ops [N];
  logic [ACC_W-1:0]         tree_sum;
  logic [ACC_W-1:0]         tree_carry;
  logic [CNT_W-1:0]         msb_cnt;
  logic signed [OUT_W-1:0]  sum_comb;

  // Split each product: top bit gated by mode, low bits to the tree.
  for (genvar i = 0; i < N; i++) begin : g_split
    assign msb_bits[i] = prod_bus[i*PW + PW - 1] & signed_mode;
    assign low_ops[i]  = prod_bus[i*PW +: LOW_W];
  end

  csa_msb_counter #(.N(N), .CNT_W(CNT_W)) u_cnt (
    .msb_bits(msb_bits),
    .msb_cnt (msb_cnt)
  );

  csa_low_tree #(.N(N), .LOW_W(LOW_W), .ACC_W(ACC_W)) u_tree (
    .low_ops  (low_ops),
    .sum_vec  (tree_sum),
    .carry_vec(tree_carry)
  );

  csa_merge_adder #(.ACC_W(ACC_W), .CNT_W(CNT_W), .OUT_W(OUT_W), .NEG_SH(LOW_W)) u_merge (
    .sum_vec  (tree_sum),
    .carry_vec(tree_carry),
    .msb_cnt  (msb_cnt),
    .total    (sum_comb)
  );

  if (REG_OUT) begin : g_reg
    logic signed [OUT_W-1:0] sum_q;
    logic signed [OUT_W-1:0] sum_d;

    always_comb begin
      sum_d = sum_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= sum_d;
    end

    assign col_sum = sum_q;

    // R4: registered output is the previous cycle's reduced value
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (col_sum == $past(sum_comb)));
  end else begin : g_comb
    assign col_sum = sum_comb;
  end

  // R3: no set top bit reaches the counter in unsigned mode
  assert_msb_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !signed_mode |-> (msb_cnt == '0));

  // R3: unsigned result never negative and never above the magnitude ceiling
  assert_unsigned_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !signed_mode |-> (sum_comb >= 0 && sum_comb <= MAX_POS));

  // R2: signed result stays inside the reachable window
  assert_signed_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    signed_mode |-> (sum_comb >= MIN_NEG && sum_comb <= MAX_POS));

  // R1: an all-zero column reduces to zero in either mode
  assert_zero_column_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_bus == '0) |-> (sum_comb == '0));

endmodule

// File: tb/csa_column_reducer_test.sv
`timescale 1ns/1ps
module csa_column_reducer_test;
  localparam int N     = 64;
  localparam int PW    = 3;
  localparam int OUT_W = 9;

  logic                    clk;
  logic                    rst_n;
  logic                    signed_mode;
  logic [N*PW-1:0]         prod_bus;
  logic signed [OUT_W-1:0] col_sum;
  logic signed [OUT_W-1:0] col_sum_c;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  csa_column_reducer #(.N(N), .PW(PW), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .signed_mode(signed_mode),
    .prod_bus(prod_bus), .col_sum(col_sum)
  );

  csa_column_reducer #(.N(N), .PW(PW), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .signed_mode(signed_mode),
    .prod_bus(prod_bus), .col_sum(col_sum_c)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int model(input logic [N*PW-1:0] v, input bit sm);
    int acc;
    logic [2:0] p;
    acc = 0;
    for (int i = 0; i < N; i++) begin
      p = v[i*PW +: PW];
      if (sm) acc += (p[2] ? int'(p) - 8 : int'(p));
      else    acc += int'(p[1:0]);
    end
    return acc;
  endfunction

  function automatic logic [N*PW-1:0] fill(input logic [2:0] p);
    logic [N*PW-1:0] v;
    for (int i = 0; i < N; i++) v[i*PW +: PW] = p;
    return v;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive on a falling edge, check both instances at their due times.
  task automatic apply(input logic [N*PW-1:0] v, input bit sm, input string req);
    int exp;
    int prev;
    exp = model(v, sm);
    @(negedge clk);
    prev = int'(col_sum);
    prod_bus    = v;
    signed_mode = sm;
    #1;
    check({req, " comb"}, int'(col_sum_c), exp);
    check("R4 hold", int'(col_sum), prev);
    @(negedge clk);
    check({req, " reg"}, int'(col_sum), exp);
  endtask

  task automatic t_reset();
    rst_n       = 1'b0;
    signed_mode = 1'b1;
    prod_bus    = fill(3'b011);
    repeat (3) @(negedge clk);
    check("R5 reset", int'(col_sum), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_signed_corners();
    apply(fill(3'b100), 1'b1, "R2 all -4");
    check("R2 min literal", model(fill(3'b100), 1'b1), -256);
    apply(fill(3'b011), 1'b1, "R2 all +3");
    apply(fill(3'b111), 1'b1, "R2 all -1");
    apply('0, 1'b1, "R1 zero");
  endtask

  task automatic t_unsigned_corners();
    apply(fill(3'b111), 1'b0, "R3 all 7");
    apply(fill(3'b100), 1'b0, "R3 all 4 ignored top");
    apply(fill(3'b011), 1'b0, "R3 all 3");
  endtask

  task automatic t_mode_switch();
    logic [N*PW-1:0] v;
    for (int i = 0; i < N; i++) v[i*PW +: PW] = (i % 2 == 0) ? 3'b101 : 3'b010;
    apply(v, 1'b1, "R6 signed");
    apply(v, 1'b0, "R6 unsigned");
    apply(v, 1'b1, "R6 signed again");
  endtask

  task automatic t_width();
    apply(fill(3'b100), 1'b1, "R7 sign bit");
    check("R7 msb set", int'(col_sum[OUT_W-1]), 1);
  endtask

  task automatic t_random();
    logic [N*PW-1:0] v;
    for (int k = 0; k < 150; k++) begin
      for (int i = 0; i < N; i++) v[i*PW +: PW] = 3'($urandom_range(0, 7));
      apply(v, k[0], "R1 random");
    end
  endtask

  initial begin
    t_reset();
    t_signed_corners();
    t_unsigned_corners();
    t_mode_switch();
    t_width();
    t_random();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule